// File: doc/BRIEF.md
# Fractional-N Divide Sequencer with Programmable Modulus

This block produces, once per phase-detector clock, the integer value that the feedback divider of a fractional-N PLL should use for the next reference period. The value is the programmed integer part plus a small signed correction from a cascade of up to four first-order accumulators. The correction is chosen so that, over time, the average divide equals the integer part plus numerator over denominator. The accumulators wrap at a programmed denominator, which can be any value from 1 to 2^32−1, not only at a power of two. Because of this, ratios such as 1/3 or 7/1000 are reproduced with no drift.

Configuration words are captured only on a load strobe. Software-style validation is applied at that point: a load with a zero denominator, a numerator not below the denominator, or an order above four is refused and raises an error flag. The modulator order selects how many accumulator stages shape the correction. Order 0 is pure integer division.

Top module: `fracNModulator`

## Requirements
- R1: With order 0 selected, every valid output equals the integer part N exactly, whatever numerator and denominator were loaded.
- R2: Each accumulator stage adds its input modulo the loaded denominator. It produces a carry of 1 when the sum reaches or exceeds the denominator, and then keeps the sum minus the denominator. Stage 1 adds the numerator, and each later stage adds the new residue of the stage before it.
- R3: The correction is the stage-1 carry plus first, second and third differences of the stage 2, 3 and 4 carries, for stages up to the loaded order. It is bounded to 0..1 for order 1, −1..2 for order 2, −3..4 for order 3 and −7..8 for order 4.
- R4: After a clearing load, the sum of the first M outputs lies within 3 of M·N + floor(M·NUM/DEN). For order 1 over M = DEN outputs, it equals N·DEN + NUM exactly. For order 0 it equals M·N.
- R5: N is 19 bits wide (up to 524287). The output is 20 bits wide and carries N + 8 without wrapping.
- R6: A load with DEN ≠ 0, NUM < DEN and order ≤ 4 is accepted. On the next edge it installs the new configuration, clears every accumulator and carry history, drops the valid flag and clears the error flag. Configuration inputs have no effect while the load strobe is low.
- R7: A load that fails the check in R6 sets the error flag on the next edge. It leaves the active configuration untouched, and the output sequence continues as if no load had occurred.
- R8: On an edge where enable is high and no accepted load is present, the modulator advances one step, the output is updated and the valid flag is high afterwards. With enable low, the valid flag is low after the edge and the output holds its value.
- R9: After reset the output is 0, the valid and error flags are low, and the active configuration is N = 0, NUM = 0, DEN = 1, order 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadStb | input | 1 | Capture configuration words on this edge |
| enable | input | 1 | Advance the modulator one step |
| cfgInt | input | 19 | Integer part N |
| cfgNum | input | 32 | Fractional numerator |
| cfgDen | input | 32 | Fractional denominator (modulus) |
| cfgOrder | input | 3 | Modulator order, 0 to 4 |
| divVal | output | 20 | Instantaneous divide value N + correction |
| divValid | output | 1 | divVal was produced by a step on the last edge |
| cfgErr | output | 1 | Last load was refused |

## Verification
All three outputs are registered, so each result is due one edge after the inputs that cause it. This applies to a step, an accepted or refused load, and a drop of enable. The bench drives inputs on the falling edge and advances its reference model for the rising edge that follows. It compares all outputs on the next falling edge, so each comparison falls exactly one edge after its stimulus. The window-sum checks accumulate these same per-cycle samples, starting with the first step after a clearing load.

// File: rtl/fracModPkg.sv
package fracModPkg;
  localparam int MASH_STAGES = 4;
  localparam int ORD_W       = 3;
  localparam int CORR_W      = 6;

  typedef struct packed {
    logic clear;
    logic step;
  } modCtrl_t;
endpackage

// File: rtl/fracModStage.sv
module fracModStage #(
  parameter int W = 32
) (
  input  logic [W-1:0] accIn,
  input  logic [W-1:0] addIn,
  input  logic [W-1:0] den,
  output logic [W-1:0] accOut,
  output logic         carry
);
  logic [W:0] sum;
  logic [W:0] wrapped;

  assign sum     = {1'b0, accIn} + {1'b0, addIn};
  assign wrapped = sum - {1'b0, den};
  assign carry   = (sum >= {1'b0, den});
  assign accOut  = carry ? wrapped[W-1:0] : sum[W-1:0];
endmodule

// File: rtl/fracModCtrl.sv
module fracModCtrl
  import fracModPkg::*;
#(
  parameter int INT_W  = 19,
  parameter int FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStb,
  input  logic              enable,
  input  logic [INT_W-1:0]  cfgInt,
  input  logic [FRAC_W-1:0] cfgNum,
  input  logic [FRAC_W-1:0] cfgDen,
  input  logic [ORD_W-1:0]  cfgOrder,
  output modCtrl_t          ctrl,
  output logic [INT_W-1:0]  actInt,
  output logic [FRAC_W-1:0] actNum,
  output logic [FRAC_W-1:0] actDen,
  output logic [ORD_W-1:0]  actOrder,
  output logic              cfgErr
);
  logic cfgOk;

  assign cfgOk = (cfgDen != '0) && (cfgNum < cfgDen) &&
                 (cfgOrder <= ORD_W'(MASH_STAGES));

  always_comb begin
    ctrl.clear = loadStb && cfgOk;
    ctrl.step  = enable && !ctrl.clear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actInt   <= '0;
      actNum   <= '0;
      actDen   <= FRAC_W'(1);
      actOrder <= '0;
      cfgErr   <= 1'b0;
    end else if (loadStb) begin
      if (cfgOk) begin
        actInt   <= cfgInt;
        actNum   <= cfgNum;
        actDen   <= cfgDen;
        actOrder <= cfgOrder;
        cfgErr   <= 1'b0;
      end else begin
        cfgErr   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fracModDatapath.sv
module fracModDatapath
  import fracModPkg::*;
#(
  parameter int INT_W  = 19,
  parameter int FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  modCtrl_t          ctrl,
  input  logic [INT_W-1:0]  actInt,
  input  logic [FRAC_W-1:0] actNum,
  input  logic [FRAC_W-1:0] actDen,
  input  logic [ORD_W-1:0]  actOrder,
  output logic [INT_W:0]    divVal,
  output logic              divValid
);
  localparam int OUT_W = INT_W + 1;

  logic [FRAC_W-1:0]      acc     [MASH_STAGES];
  logic [FRAC_W-1:0]      accNext [MASH_STAGES];
  logic [MASH_STAGES-1:0] carry;
  logic                   c2d1;
  logic [1:0]             c3d;
  logic [2:0]             c4d;
  logic signed [CORR_W-1:0] t1, t2, t3, t4, corr;
  logic [OUT_W-1:0]       nextVal;

  for (genvar s = 0; s < MASH_STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      fracModStage #(.W(FRAC_W)) stage_i (
        .accIn(acc[s]), .addIn(actNum), .den(actDen),
        .accOut(accNext[s]), .carry(carry[s]));
    end else begin : g_chain
      fracModStage #(.W(FRAC_W)) stage_i (
        .accIn(acc[s]), .addIn(accNext[s-1]), .den(actDen),
        .accOut(accNext[s]), .carry(carry[s]));
    end
  end

  function automatic logic signed [CORR_W-1:0] sx(input logic b);
    return $signed({{(CORR_W-1){1'b0}}, b});
  endfunction

  always_comb begin
    t1 = sx(carry[0]);
    t2 = sx(carry[1]) - sx(c2d1);
    t3 = sx(carry[2]) - 6'sd2 * sx(c3d[0]) + sx(c3d[1]);
    t4 = sx(carry[3]) - 6'sd3 * sx(c4d[0]) + 6'sd3 * sx(c4d[1]) - sx(c4d[2]);
    case (actOrder)
      3'd1:    corr = t1;
      3'd2:    corr = t1 + t2;
      3'd3:    corr = t1 + t2 + t3;
      3'd4:    corr = t1 + t2 + t3 + t4;
      default: corr = '0;
    endcase
    nextVal = {1'b0, actInt} + {{(OUT_W-CORR_W){corr[CORR_W-1]}}, corr};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < MASH_STAGES; s++) acc[s] <= '0;
      c2d1     <= 1'b0;
      c3d      <= '0;
      c4d      <= '0;
      divVal   <= '0;
      divValid <= 1'b0;
    end else if (ctrl.clear) begin
      for (int s = 0; s < MASH_STAGES; s++) acc[s] <= '0;
      c2d1     <= 1'b0;
      c3d      <= '0;
      c4d      <= '0;
      divValid <= 1'b0;
    end else if (ctrl.step) begin
      for (int s = 0; s < MASH_STAGES; s++) acc[s] <= accNext[s];
      c2d1     <= carry[1];
      c3d      <= {c3d[0], carry[2]};
      c4d      <= {c4d[1:0], carry[3]};
      divVal   <= nextVal;
      divValid <= 1'b1;
    end else begin
      divValid <= 1'b0;
    end
  end
endmodule

// File: rtl/fracNModulator.sv
module fracNModulator
  import fracModPkg::*;
#(
  parameter int INT_W  = 19,
  parameter int FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStb,
  input  logic              enable,
  input  logic [INT_W-1:0]  cfgInt,
  input  logic [FRAC_W-1:0] cfgNum,
  input  logic [FRAC_W-1:0] cfgDen,
  input  logic [ORD_W-1:0]  cfgOrder,
  output logic [INT_W:0]    divVal,
  output logic              divValid,
  output logic              cfgErr
);
  modCtrl_t          ctrl;
  logic [INT_W-1:0]  actInt;
  logic [FRAC_W-1:0] actNum;
  logic [FRAC_W-1:0] actDen;
  logic [ORD_W-1:0]  actOrder;

  fracModCtrl #(.INT_W(INT_W), .FRAC_W(FRAC_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .enable(enable),
    .cfgInt(cfgInt), .cfgNum(cfgNum), .cfgDen(cfgDen), .cfgOrder(cfgOrder),
    .ctrl(ctrl), .actInt(actInt), .actNum(actNum), .actDen(actDen),
    .actOrder(actOrder), .cfgErr(cfgErr));

  fracModDatapath #(.INT_W(INT_W), .FRAC_W(FRAC_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .actInt(actInt), .actNum(actNum),
    .actDen(actDen), .actOrder(actOrder), .divVal(divVal), .divValid(divValid));
endmodule

// File: rtl/fracNModulatorChk.sv
module fracNModulatorChk #(
  parameter int INT_W  = 19,
  parameter int FRAC_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadStb,
  input logic              enable,
  input logic [FRAC_W-1:0] cfgNum,
  input logic [FRAC_W-1:0] cfgDen,
  input logic [2:0]        cfgOrder,
  input logic [INT_W:0]    divVal,
  input logic              divValid,
  input logic              cfgErr,
  input logic [INT_W-1:0]  actInt,
  input logic [FRAC_W-1:0] actDen,
  input logic [2:0]        actOrder
);
  logic goodLoad;
  int   diffV;
  int   loB;
  int   hiB;

  assign goodLoad = (cfgDen != '0) && (cfgNum < cfgDen) && (cfgOrder <= 3'd4);

  always_comb begin
    diffV = int'(divVal) - int'(actInt);
    case (actOrder)
      3'd1:    begin loB = 0;  hiB = 1; end
      3'd2:    begin loB = -1; hiB = 2; end
      3'd3:    begin loB = -3; hiB = 4; end
      3'd4:    begin loB = -7; hiB = 8; end
      default: begin loB = 0;  hiB = 0; end
    endcase
  end

  // R1
  a_r1_order0_exact: assert property (@(posedge clk) disable iff (!rstN)
    (divValid && actOrder == 3'd0) |-> (diffV == 0));
  // R3
  a_r3_corr_bounds: assert property (@(posedge clk) disable iff (!rstN)
    divValid |-> (diffV >= loB && diffV <= hiB));
  // R6
  a_r6_load_clears: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && goodLoad) |=> (!divValid && !cfgErr));
  // R7
  a_r7_reject_flags: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && !goodLoad) |=> (cfgErr && $stable(actDen) && $stable(actOrder)));
  // R8
  a_r8_step_valid: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !loadStb) |=> divValid);
  // R8
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !loadStb) |=> (!divValid && $stable(divVal)));
endmodule

bind fracNModulator fracNModulatorChk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) chk_i (
  .clk(clk), .rstN(rstN), .loadStb(loadStb), .enable(enable),
  .cfgNum(cfgNum), .cfgDen(cfgDen), .cfgOrder(cfgOrder),
  .divVal(divVal), .divValid(divValid), .cfgErr(cfgErr),
  .actInt(actInt), .actDen(actDen), .actOrder(actOrder));

// File: tb/fracNModulator_tb_top.sv
module fracNModulator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int INT_W  = 19;
  localparam int FRAC_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              loadStb = 1'b0;
  logic              enable = 1'b0;
  logic [INT_W-1:0]  cfgInt = '0;
  logic [FRAC_W-1:0] cfgNum = '0;
  logic [FRAC_W-1:0] cfgDen = '0;
  logic [2:0]        cfgOrder = '0;
  logic [INT_W:0]    divVal;
  logic              divValid;
  logic              cfgErr;

  fracNModulator #(.INT_W(INT_W), .FRAC_W(FRAC_W)) dut_i (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .enable(enable),
    .cfgInt(cfgInt), .cfgNum(cfgNum), .cfgDen(cfgDen), .cfgOrder(cfgOrder),
    .divVal(divVal), .divValid(divValid), .cfgErr(cfgErr));

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nFail   = 0;

  // reference model state
  longint mN = 0, mNum = 0, mDen = 1;
  int     mOrd = 0;
  longint mAcc [4];
  int     mHist [4][$];
  bit     mValid = 0, mErr = 0;
  longint mOut = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int binom(int n, int k);
    int r = 1;
    for (int i = 0; i < k; i++) r = r * (n - i) / (i + 1);
    return r;
  endfunction

  task automatic modelClear();
    for (int s = 0; s < 4; s++) begin
      mAcc[s] = 0;
      mHist[s] = {0, 0, 0};
    end
  endtask

  task automatic modelEdge(bit ld, bit en, longint n, longint num, longint den, int ord);
    bit accept = ld && den != 0 && num < den && ord <= 4;
    if (ld) mErr = !accept;
    if (accept) begin
      mN = n; mNum = num; mDen = den; mOrd = ord;
      modelClear();
      mValid = 0;
    end else if (en) begin
      longint x = mNum;
      int corr = 0;
      for (int s = 0; s < 4; s++) begin
        int c;
        mAcc[s] = mAcc[s] + x;
        c = (mAcc[s] >= mDen) ? 1 : 0;
        if (c == 1) mAcc[s] = mAcc[s] - mDen;
        x = mAcc[s];
        mHist[s].push_front(c);
      end
      for (int s = 0; s < mOrd; s++)
        for (int j = 0; j <= s; j++)
          corr += ((j % 2 == 0) ? 1 : -1) * binom(s, j) * mHist[s][j];
      for (int s = 0; s < 4; s++) void'(mHist[s].pop_back());
      mOut = mN + corr;
      mValid = 1;
    end else begin
      mValid = 0;
    end
  endtask

  task automatic tick(bit ld, bit en, longint n, longint num, longint den, int ord, string req);
    loadStb = ld;
    enable  = en;
    if (ld) begin
      cfgInt = n[INT_W-1:0]; cfgNum = num[FRAC_W-1:0];
      cfgDen = den[FRAC_W-1:0]; cfgOrder = ord[2:0];
    end else begin
      // R6: configuration inputs must be ignored without a load
      cfgInt = INT_W'($urandom); cfgNum = $urandom; cfgDen = $urandom;
      cfgOrder = 3'($urandom);
    end
    modelEdge(ld, en, n, num, den, ord);
    @(posedge clk);
    @(negedge clk);
    chk(divValid == mValid, req, "divValid", longint'(divValid), longint'(mValid));
    chk(cfgErr == mErr, req, "cfgErr", longint'(cfgErr), longint'(mErr));
    chk(longint'(divVal) == mOut, req, "divVal", longint'(divVal), mOut);
  endtask

  task automatic runWindow(int m, longint n, longint num, longint den, int ord,
                           int tol, string req);
    longint sum = 0, exp, diff;
    for (int i = 0; i < m; i++) begin
      tick(0, 1, 0, 0, 0, 0, req);
      sum += longint'(divVal);
    end
    exp = (ord == 0) ? longint'(m) * n : longint'(m) * n + (longint'(m) * num) / den;
    diff = sum - exp;
    if (diff < 0) diff = -diff;
    chk(diff <= tol, req, "window sum", sum, exp);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFail++;
    $display("FAIL R8 watchdog expired: actual 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    modelClear();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(divVal == '0, "R9", "reset divVal", longint'(divVal), 0);
    chk(!divValid, "R9", "reset divValid", longint'(divValid), 0);
    chk(!cfgErr, "R9", "reset cfgErr", longint'(cfgErr), 0);
    // R9: stepping the reset config gives N=0 order 0
    tick(0, 1, 0, 0, 0, 0, "R9");

    // R2 R4: order 1, 1/3, exact over DEN steps
    tick(1, 0, 100, 1, 3, 1, "R6");
    runWindow(3, 100, 1, 3, 1, 0, "R4");
    runWindow(27, 100, 1, 3, 1, 0, "R2");

    // R3 R4: order 2, 7/1000
    tick(1, 1, 40, 7, 1000, 2, "R6");
    runWindow(1000, 40, 7, 1000, 2, 3, "R4");

    // R8: enable low holds output
    tick(0, 0, 0, 0, 0, 0, "R8");
    tick(0, 0, 0, 0, 0, 0, "R8");
    tick(0, 1, 0, 0, 0, 0, "R8");

    // R3 R4: order 3 odd modulus
    tick(1, 0, 60, 12345, 65537, 3, "R6");
    runWindow(2000, 60, 12345, 65537, 3, 3, "R3");

    // R5: max N with order 4 near-full fraction
    tick(1, 0, 524287, 64'd4294967294, 64'd4294967295, 4, "R5");
    runWindow(300, 524287, 64'd4294967294, 64'd4294967295, 4, 3, "R5");

    // R3 R4: order 4, small N
    tick(1, 0, 28, 5, 9, 4, "R6");
    runWindow(900, 28, 5, 9, 4, 3, "R4");

    // R7: rejected loads keep sequence running
    tick(1, 1, 50, 9, 9, 2, "R7");
    tick(0, 1, 0, 0, 0, 0, "R7");
    tick(1, 1, 50, 1, 0, 2, "R7");
    tick(1, 0, 50, 1, 3, 5, "R7");
    runWindow(20, 28, 5, 9, 4, 40, "R7");

    // R1: order 0 with nonzero fraction
    tick(1, 1, 28, 5, 9, 0, "R6");
    runWindow(20, 28, 5, 9, 0, 0, "R1");

    // R6: reload restarts deterministic sequence
    tick(1, 1, 77, 3, 7, 3, "R6");
    runWindow(7, 77, 3, 7, 3, 3, "R6");
    tick(1, 1, 77, 3, 7, 3, "R6");
    runWindow(7, 77, 3, 7, 3, 3, "R6");

    summary();
    $finish;
  end
endmodule